// File: doc/BRIEF.md
# SIMD widening shift-left unit

This unit decodes and executes the vector shift-left-long operation on one 128-bit SIMD register value. Each cycle in which `in_strobe` is high it takes a 32-bit instruction word and the contents of the source register. It checks the word against the fixed opcode bits. On a hit it picks the lower or upper 64-bit half of the source and widens every element of that half to a lane of twice its width. The element becomes the upper half of its lane and the lower half of the lane is zero. This equals zero-extension followed by a left shift of one element width.

The unit registers the result, both register indices and two flags on the next rising clock edge. A caller that owns the register file uses `out_dest` to write `out_result` back. The unit flags the reserved element-size code as undefined, and then it returns a zero result. Condition flags are outside this block and are never touched.

Top module: `wsl_unit`

## Requirements
- R1: Bit 30 and bits 23:22 of `insn` are free. The fixed bits must read: bit31=0, bit29=1, bits28:24=01110, bits21:17=10000, bits16:12=10011, bits11:10=10, so that `(insn & 32'hBF3FFC00) == 32'h2E213800`. `out_match` is 1 only when the fixed bits hold and bits 23:22 are not 11.
- R2: Bit 30 selects the source half. With 0 the elements come from `src[63:0]`. With 1 they come from `src[127:64]`.
- R3: Bits 23:22 set the element width E: 00 gives E=8, 01 gives E=16, 10 gives E=32. With the selected half called H, there are 64/E lanes of 2E bits. Result lane e occupies bits [2E*e+2E-1 : 2E*e]. Its upper E bits equal H[E*e+E-1 : E*e].
- R4: Elements are unsigned. The lower E bits of every lane are zero, and an element with its top bit set is not sign-extended.
- R5: When the fixed bits hold and bits 23:22 are 11, `out_undef` is 1, `out_match` is 0 and `out_result` is zero.
- R6: When any fixed bit differs, `out_match`, `out_undef` and `out_result` are all zero.
- R7: `out_dest` takes `insn[4:0]` and `out_srcidx` takes `insn[9:5]` for every strobed word, whether or not it matches.
- R8: A strobe at one rising edge makes the outputs update at that edge. `out_valid` is 1 for exactly the cycle that follows the strobe. With no strobe, `out_valid` is 0 and all other outputs hold their values.
- R9: When `rst` is high at a rising edge, all outputs are cleared to zero. This holds even when `in_strobe` is high at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_strobe | input | 1 | Inputs are taken at this edge |
| insn | input | 32 | Instruction word |
| src | input | 128 | Source register contents |
| out_valid | output | 1 | High for the cycle after a strobe |
| out_match | output | 1 | Word is the widening shift with a legal size |
| out_undef | output | 1 | Word has the opcode bits but the reserved size |
| out_dest | output | 5 | Destination register index |
| out_srcidx | output | 5 | Source register index |
| out_result | output | 128 | Widened and shifted vector |

## Verification
A synchronous reset and an input strobe can arrive at the same rising edge. The bench raises both together while the outputs hold a nonzero result from an earlier operation. The expected outcome is all-zero outputs with `out_valid` low, which shows that reset wins. A second case pairs half selection with lane widening in the same word. The source halves are filled with different patterns, so a wrong half or a wrong lane placement shows up as a mismatch against the bench's lane-by-lane model.

// File: rtl/wsl_pkg.sv
package wsl_pkg;

    localparam logic [31:0] OPC_MASK  = 32'hBF3F_FC00;
    localparam logic [31:0] OPC_VALUE = 32'h2E21_3800;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } esize_e;

    typedef struct packed {
        logic       hit;
        logic       undef;
        logic       upper;
        esize_e     size;
        logic [4:0] rd;
        logic [4:0] rn;
    } dec_t;

    typedef struct packed {
        logic       valid;
        logic       hit;
        logic       undef;
        logic [4:0] rd;
        logic [4:0] rn;
    } ctl_t;

    function automatic dec_t decode_word(input logic [31:0] w);
        dec_t d;
        logic fixed_ok;
        fixed_ok = ((w & OPC_MASK) == OPC_VALUE);
        d.size   = esize_e'(w[23:22]);
        d.upper  = w[30];
        d.rd     = w[4:0];
        d.rn     = w[9:5];
        d.hit    = fixed_ok && (d.size != SZ_RSVD);
        d.undef  = fixed_ok && (d.size == SZ_RSVD);
        return d;
    endfunction

endpackage

// File: rtl/wsl_decode.sv
module wsl_decode
    import wsl_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);
    always_comb begin
        dec = decode_word(word);
    end
endmodule

// File: rtl/wsl_widen.sv
module wsl_widen #(
    parameter int DATA_W = 128,
    parameter int ESIZE  = 8
) (
    input  logic [DATA_W/2-1:0] half,
    output logic [DATA_W-1:0]   wide
);
    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = HALF_W / ESIZE;
    localparam int LANE_W = 2 * ESIZE;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        assign wide[e*LANE_W +: LANE_W] = {half[e*ESIZE +: ESIZE], {ESIZE{1'b0}}};
    end
endmodule

// File: rtl/wsl_outreg.sv
module wsl_outreg
    import wsl_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  ctl_t              ctl_in,
    input  logic [DATA_W-1:0] res_in,
    output ctl_t              ctl_q,
    output logic [DATA_W-1:0] res_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            res_q <= '0;
        end else if (take) begin
            ctl_q <= ctl_in;
            res_q <= res_in;
        end else begin
            ctl_q.valid <= 1'b0;
        end
    end
endmodule

// File: rtl/wsl_unit.sv
module wsl_unit
    import wsl_pkg::*;
#(
    parameter int DATA_W     = 128,
    parameter int BASE_ESIZE = 8,
    parameter int NUM_SIZES  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_strobe,
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] src,
    output logic              out_valid,
    output logic              out_match,
    output logic              out_undef,
    output logic [4:0]        out_dest,
    output logic [4:0]        out_srcidx,
    output logic [DATA_W-1:0] out_result
);
    localparam int HALF_W = DATA_W / 2;

    dec_t              dec;
    logic [HALF_W-1:0] half_sel;
    logic [DATA_W-1:0] wide_arr [NUM_SIZES];
    logic [DATA_W-1:0] res_next;
    ctl_t              ctl_next;
    ctl_t              ctl_q;

    wsl_decode u_dec (
        .word (insn),
        .dec  (dec)
    );

    assign half_sel = dec.upper ? src[DATA_W-1:HALF_W] : src[HALF_W-1:0];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        wsl_widen #(
            .DATA_W (DATA_W),
            .ESIZE  (BASE_ESIZE << k)
        ) u_widen (
            .half (half_sel),
            .wide (wide_arr[k])
        );
    end

    always_comb begin
        res_next = '0;
        for (int k = 0; k < NUM_SIZES; k++) begin
            if (dec.hit && (int'(dec.size) == k)) begin
                res_next = wide_arr[k];
            end
        end
    end

    always_comb begin
        ctl_next.valid = 1'b1;
        ctl_next.hit   = dec.hit;
        ctl_next.undef = dec.undef;
        ctl_next.rd    = dec.rd;
        ctl_next.rn    = dec.rn;
    end

    wsl_outreg #(.DATA_W(DATA_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .take   (in_strobe),
        .ctl_in (ctl_next),
        .res_in (res_next),
        .ctl_q  (ctl_q),
        .res_q  (out_result)
    );

    assign out_valid  = ctl_q.valid;
    assign out_match  = ctl_q.hit;
    assign out_undef  = ctl_q.undef;
    assign out_dest   = ctl_q.rd;
    assign out_srcidx = ctl_q.rn;
endmodule

// File: rtl/wsl_unit_chk.sv
module wsl_unit_chk
    import wsl_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              in_strobe,
    input logic [31:0]       insn,
    input logic              out_valid,
    input logic              out_match,
    input logic              out_undef,
    input logic [4:0]        out_dest,
    input logic [4:0]        out_srcidx,
    input logic [DATA_W-1:0] out_result
);
    a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        in_strobe |=> out_valid);

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_strobe |=> (!out_valid && $stable(out_result) && $stable(out_dest)));

    a_r7_indices: assert property (@(posedge clk) disable iff (rst)
        in_strobe |=> (out_dest == $past(insn[4:0]) && out_srcidx == $past(insn[9:5])));

    a_r6_foreign_word: assert property (@(posedge clk) disable iff (rst)
        (in_strobe && ((insn & OPC_MASK) != OPC_VALUE)) |=> (!out_match && !out_undef && out_result == '0));

    a_r5_reserved_size: assert property (@(posedge clk) disable iff (rst)
        (in_strobe && ((insn & OPC_MASK) == OPC_VALUE) && insn[23:22] == 2'b11)
        |=> (out_undef && !out_match && out_result == '0));

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_match && out_undef));

    a_r4_low_byte_zero: assert property (@(posedge clk) disable iff (rst)
        out_match |-> (out_result[7:0] == 8'h00));

    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !out_match && out_result == '0));
endmodule

bind wsl_unit wsl_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_strobe  (in_strobe),
    .insn       (insn),
    .out_valid  (out_valid),
    .out_match  (out_match),
    .out_undef  (out_undef),
    .out_dest   (out_dest),
    .out_srcidx (out_srcidx),
    .out_result (out_result)
);

// File: tb/wsl_unit_tb.sv
`timescale 1ns/1ps
module wsl_unit_tb;
    localparam logic [31:0] MASK = 32'hBF3F_FC00;
    localparam logic [31:0] BASE = 32'h2E21_3800;
    localparam int NV = 10;

    localparam logic [31:0] T_INSN [NV] = '{
        32'h2E21_38A3, 32'h6E21_381F, 32'h2E61_3861, 32'h6E61_38E2,
        32'h2EA1_3C00, 32'h6EA1_3BFF, 32'h2EE1_3800, 32'h6EE1_3821,
        32'h0000_0000, 32'h2EA1_3844
    };
    localparam logic [127:0] T_SRC [NV] = '{
        128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF,
        128'h8899_AABB_CCDD_EEFF_1122_3344_5566_7788,
        128'h0F0F_0F0F_0F0F_0F0F_FFFF_8000_7FFF_0001,
        128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000,
        128'h1111_2222_3333_4444_5555_6666_7777_8888,
        128'hDEAD_BEEF_8000_0001_0BAD_F00D_1234_5678,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'hA5A5_A5A5_A5A5_A5A5_5A5A_5A5A_5A5A_5A5A,
        128'h0123_4567_89AB_CDEF_0123_4567_89AB_CDEF,
        128'h0000_0000_0000_0000_8765_4321_FFFF_FFFF
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_strobe = 1'b0;
    logic [31:0]  insn = '0;
    logic [127:0] src = '0;
    logic         out_valid, out_match, out_undef;
    logic [4:0]   out_dest, out_srcidx;
    logic [127:0] out_result;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wsl_unit u_dut (
        .clk(clk), .rst(rst), .in_strobe(in_strobe), .insn(insn), .src(src),
        .out_valid(out_valid), .out_match(out_match), .out_undef(out_undef),
        .out_dest(out_dest), .out_srcidx(out_srcidx), .out_result(out_result)
    );

    function automatic bit fixed_ok(logic [31:0] w);
        return (w & MASK) == BASE;
    endfunction

    function automatic logic exp_match(logic [31:0] w);
        return fixed_ok(w) && (w[23:22] != 2'b11);
    endfunction

    function automatic logic exp_undef(logic [31:0] w);
        return fixed_ok(w) && (w[23:22] == 2'b11);
    endfunction

    function automatic logic [127:0] exp_result(logic [31:0] w, logic [127:0] s);
        logic [127:0] r;
        logic [63:0]  h;
        int es;
        r = '0;
        if (!exp_match(w)) return r;
        es = 8 << w[23:22];
        h  = w[30] ? s[127:64] : s[63:0];
        for (int e = 0; e < 64 / es; e++)
            for (int b = 0; b < es; b++)
                r[e*2*es + es + b] = h[e*es + b];
        return r;
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] w, logic [127:0] s);
        @(negedge clk);
        insn = w; src = s; in_strobe = 1'b1;
        @(negedge clk);
        in_strobe = 1'b0;
    endtask

    task automatic check_op(string req, logic [31:0] w, logic [127:0] s);
        chk({req, " valid"}, 128'(out_valid), 128'd1);
        chk({req, " match"}, 128'(out_match), 128'(exp_match(w)));
        chk({req, " undef"}, 128'(out_undef), 128'(exp_undef(w)));
        chk({req, " result"}, out_result, exp_result(w, s));
        chk({req, " R7 idx"}, 128'({out_srcidx, out_dest}), 128'(w[9:0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk("R9 reset state", {out_result[122:0], out_valid, out_match, out_undef, |out_dest, |out_srcidx}, '0);

        // R1 R2 R3 R4 R5 R6 R7 table walk
        for (int i = 0; i < NV; i++) begin
            issue(T_INSN[i], T_SRC[i]);
            check_op("R1-table R2 R3 R4 R5 R6", T_INSN[i], T_SRC[i]);
        end

        // R4 top-bit elements, 16-bit lanes, upper half
        issue(32'h6E61_3800, 128'h8000_FFFF_8001_7FFF_0000_0000_0000_0000);
        chk("R4 no sign extension", out_result, 128'h8000_0000_FFFF_0000_8001_0000_7FFF_0000);

        // R3 explicit byte lanes, lower half
        issue(32'h2E21_3800, 128'h0000_0000_0000_0000_0807_0605_0403_0201);
        chk("R3 byte lanes", out_result, 128'h0800_0700_0600_0500_0400_0300_0200_0100);

        // R8 hold with no strobe
        held = out_result;
        @(negedge clk);
        chk("R8 valid drops", 128'(out_valid), 128'd0);
        insn = 32'h0; src = '0;
        @(negedge clk);
        chk("R8 result held", out_result, held);

        // R6 every fixed bit flipped
        for (int b = 0; b < 32; b++) begin
            if (MASK[b]) begin
                issue(BASE ^ (32'd1 << b), {4{32'hCAFE_F00D}});
                chk("R6 flipped bit", {out_result[125:0], out_match, out_undef}, '0);
            end
        end

        // R5 reserved size on upper half
        issue(32'h6EE1_3800, '1);
        chk("R5 reserved", {out_result[125:0], out_match, out_undef}, 128'd1);

        // R9 reset and strobe at the same edge
        issue(32'h2EA1_3800, '1);
        @(negedge clk);
        rst = 1'b1; in_strobe = 1'b1; insn = 32'h2E21_38FF; src = '1;
        @(negedge clk);
        rst = 1'b0; in_strobe = 1'b0;
        chk("R9 reset beats strobe", {out_result[122:0], out_valid, out_match, out_undef, |out_dest, |out_srcidx}, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule